// File: doc/BRIEF.md
# Gated divided clock channel

This block is one peripheral clock channel of a clock management unit. It picks one of several reference clock-enable streams, divides it by a programmable ratio and emits the result as a clock-enable pulse stream. A gate stage decides whether the channel runs. A separate running-status bit reports the gate state after a fixed synchronizer delay, so software can poll it before it relies on the output.

Software reaches the channel through a small register bus. Writes are accepted only while the unit-level access-enable input is high. Ratio and source writes land in staged copies and have no effect on the output. A self-clearing trigger moves the staged copies into the active copies in a single step and restarts the divider. The gate follows either a software enable bit or an external hardware request, as chosen by a control bit.

Top module: `pclk_chan`

## Requirements
- R1: The register address selects one of four registers. Address 0 is the gate register: bit 0 is the software enable, bit 1 is the control select (1 = software), and bit 4 is the read-only running status. Address 1 is the ratio register: staged value in the low bits, active value from bit 8 upward. Address 2 is the source register, laid out the same way. Address 3 is the trigger register, bit 0. Reads are combinational, and unused bits read 0.
- R2: While rst_n is low at a clock edge, every register field, the running status and ce_out go to 0.
- R3: A write takes effect only when wr_en and acc_en are both high at the edge. With acc_en low, a write to any register, including the trigger, changes nothing.
- R4: With the control select at 1 the gate follows the software enable bit. With it at 0 the gate follows hw_req, and the software enable bit is ignored.
- R5: The running status equals the gate request as it was SYNC_DLY clock edges earlier.
- R6: Writes to the ratio or source register change only the staged values. The active values and the output pulse rate stay unchanged until a trigger.
- R7: An accepted write with bit 0 set to the trigger register makes the trigger read 1 for exactly one cycle. At the following edge the staged ratio and source are copied to the active values, the divider count restarts at zero and the trigger reads 0.
- R8: An active ratio field f gives one output pulse for every f+1 ticks of the selected source, counted from the restart. A field of 0 passes every tick.
- R9: The active source field s selects src_en[s], and ce_out is high only in a cycle where that source ticks.
- R10: ce_out stays 0 whenever the running status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Write permission from the unit-level unlock logic |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| hw_req | input | 1 | Hardware request, used when the control select is 0 |
| src_en | input | NUM_SRC | Reference clock-enable streams, one bit per source |
| ce_out | output | 1 | Divided, gated clock-enable pulses |

## Verification
Register readback is due in the cycle after the write edge, and the bench reads it half a cycle after that edge. The trigger bit is sampled in that same cycle and again after one more edge, where it must read 0 and the active fields must already hold the staged values. The running status is sampled after SYNC_DLY-1 edges and again after SYNC_DLY edges, counted from the edge that changed the gate request, so an off-by-one lag fails. Every pulse-count window opens at the restart edge, so the expected count is the number of selected source ticks divided by the ratio and does not depend on the phase of the source.

// File: rtl/pclk_chan_pkg.sv
// Package pclk_chan_pkg
// Shared register addresses, bit positions and types of the clock channel.
// Assumes a data word of at least 16 bits, with active fields placed in the upper half.
package pclk_chan_pkg;

    typedef logic [1:0] reg_addr_t;

    localparam reg_addr_t REG_GATE = 2'd0;
    localparam reg_addr_t REG_DIV  = 2'd1;
    localparam reg_addr_t REG_SEL  = 2'd2;
    localparam reg_addr_t REG_TRIG = 2'd3;

    localparam int GATE_EN_BIT  = 0;
    localparam int GATE_SW_BIT  = 1;
    localparam int GATE_RUN_BIT = 4;
    localparam int TRIG_BIT     = 0;

    // Width of the source field; a single-source channel keeps one tied-off bit.
    function automatic int sel_width(input int n_src);
        return (n_src > 1) ? $clog2(n_src) : 1;
    endfunction

endpackage

// File: rtl/pclk_chan_regs.sv
// Module pclk_chan_regs
// Register file of the channel: gate controls, staged and active ratio and
// source fields, and the self-clearing trigger. It assumes DIV_W and SEL_W
// each fit in half of DATA_W. With one source, the source fields are tied to 0.
module pclk_chan_regs
    import pclk_chan_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DIV_W   = 4,
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              wr_en,
    input  reg_addr_t         addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              run_st,
    output logic [DATA_W-1:0] rdata,
    output logic              sw_ctl,
    output logic              sw_en,
    output logic              trig_pend,
    output logic [DIV_W-1:0]  div_stg,
    output logic [DIV_W-1:0]  div_act,
    output logic [SEL_W-1:0]  sel_stg,
    output logic [SEL_W-1:0]  sel_act
);

    localparam int HALF = DATA_W / 2;

    logic wr_ok;
    logic unused_wdata;

    assign wr_ok        = wr_en && acc_en;
    assign unused_wdata = ^wdata;

    // Gate bits, staged ratio, ratio commit and trigger pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_ctl    <= 1'b0;
            sw_en     <= 1'b0;
            div_stg   <= '0;
            div_act   <= '0;
            trig_pend <= 1'b0;
        end else begin
            if (wr_ok && addr == REG_GATE) begin
                sw_en  <= wdata[GATE_EN_BIT];
                sw_ctl <= wdata[GATE_SW_BIT];
            end
            if (wr_ok && addr == REG_DIV) begin
                div_stg <= wdata[DIV_W-1:0];
            end
            if (trig_pend) begin
                div_act <= div_stg;
            end
            trig_pend <= wr_ok && (addr == REG_TRIG) && wdata[TRIG_BIT];
        end
    end

    generate
        if (NUM_SRC > 1) begin : g_sel
            // Staged source field and its commit on the trigger.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel_stg <= '0;
                    sel_act <= '0;
                end else begin
                    if (wr_ok && addr == REG_SEL) begin
                        sel_stg <= wdata[SEL_W-1:0];
                    end
                    if (trig_pend) begin
                        sel_act <= sel_stg;
                    end
                end
            end
        end else begin : g_nosel
            assign sel_stg = '0;
            assign sel_act = '0;
        end
    endgenerate

    // Combinational read mux; unused bits read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_GATE: begin
                rdata[GATE_EN_BIT]  = sw_en;
                rdata[GATE_SW_BIT]  = sw_ctl;
                rdata[GATE_RUN_BIT] = run_st;
            end
            REG_DIV: begin
                rdata[DIV_W-1:0]    = div_stg;
                rdata[HALF +: DIV_W] = div_act;
            end
            REG_SEL: begin
                rdata[SEL_W-1:0]    = sel_stg;
                rdata[HALF +: SEL_W] = sel_act;
            end
            default: begin
                rdata[TRIG_BIT] = trig_pend;
            end
        endcase
    end

endmodule

// File: rtl/pclk_chan_gate.sv
// Module pclk_chan_gate
// Chooses the gate request (software bit or hardware request) and delays it
// through a SYNC_DLY-stage chain to form the running status. SYNC_DLY >= 1.
module pclk_chan_gate #(
    parameter int SYNC_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_ctl,
    input  logic sw_en,
    input  logic hw_req,
    output logic gate_req,
    output logic run_st
);

    logic [SYNC_DLY-1:0] sync_q;

    assign gate_req = sw_ctl ? sw_en : hw_req;
    assign run_st   = sync_q[SYNC_DLY-1];

    generate
        if (SYNC_DLY == 1) begin : g_one
            // Single-stage status delay.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= gate_req;
            end
        end else begin : g_chain
            // Multi-stage status delay chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_DLY-2:0], gate_req};
            end
        end
    endgenerate

endmodule

// File: rtl/pclk_chan_div.sv
// Module pclk_chan_div
// Selects one reference tick stream and divides it by (div_act + 1). The
// counter restarts at zero on a commit. Output pulses are masked while the
// channel is not running. An out-of-range source index yields no ticks.
module pclk_chan_div #(
    parameter int NUM_SRC = 4,
    parameter int DIV_W   = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [SEL_W-1:0]   sel_act,
    input  logic [DIV_W-1:0]   div_act,
    input  logic               restart,
    input  logic               run_st,
    output logic               ce_out
);

    logic [DIV_W-1:0] cnt_q;
    logic             src_tick;
    logic             at_end;

    // Pick the selected reference tick.
    always_comb begin
        src_tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(sel_act) == i) src_tick = src_en[i];
        end
    end

    assign at_end = (cnt_q == div_act);
    assign ce_out = src_tick && at_end && run_st;

    // Tick counter with restart on commit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (src_tick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pclk_chan.sv
// Module pclk_chan
// One gated, divided clock-enable channel: register file, gate with status
// delay, and source select and divider. The output is an enable pulse stream,
// not a muxed clock.
module pclk_chan
    import pclk_chan_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_SRC  = 4,
    parameter int DIV_W    = 4,
    parameter int SYNC_DLY = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               hw_req,
    input  logic [NUM_SRC-1:0] src_en,
    output logic               ce_out
);

    localparam int SEL_W = sel_width(NUM_SRC);

    logic             sw_ctl;
    logic             sw_en;
    logic             trig_pend;
    logic             gate_req;
    logic             run_st;
    logic [DIV_W-1:0] div_stg;
    logic [DIV_W-1:0] div_act;
    logic [SEL_W-1:0] sel_stg;
    logic [SEL_W-1:0] sel_act;

    pclk_chan_regs #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W),
        .NUM_SRC(NUM_SRC),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .run_st   (run_st),
        .rdata    (rdata),
        .sw_ctl   (sw_ctl),
        .sw_en    (sw_en),
        .trig_pend(trig_pend),
        .div_stg  (div_stg),
        .div_act  (div_act),
        .sel_stg  (sel_stg),
        .sel_act  (sel_act)
    );

    pclk_chan_gate #(
        .SYNC_DLY(SYNC_DLY)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_ctl  (sw_ctl),
        .sw_en   (sw_en),
        .hw_req  (hw_req),
        .gate_req(gate_req),
        .run_st  (run_st)
    );

    pclk_chan_div #(
        .NUM_SRC(NUM_SRC),
        .DIV_W  (DIV_W),
        .SEL_W  (SEL_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_en (src_en),
        .sel_act(sel_act),
        .div_act(div_act),
        .restart(trig_pend),
        .run_st (run_st),
        .ce_out (ce_out)
    );

endmodule

// File: rtl/pclk_chan_chk.sv
// Module pclk_chan_chk
// Property checker bound to pclk_chan. It watches the bus, the gate request,
// the running status and the staged and active fields. The status lag is
// checked with a saturating counter of stable request samples, not a deep $past.
module pclk_chan_chk #(
    parameter int NUM_SRC  = 4,
    parameter int DIV_W    = 4,
    parameter int SEL_W    = 2,
    parameter int SYNC_DLY = 4,
    parameter int DATA_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic               wr_en,
    input logic [1:0]         addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [NUM_SRC-1:0] src_en,
    input logic               ce_out,
    input logic               gate_req,
    input logic               run_st,
    input logic               trig_pend,
    input logic [DIV_W-1:0]   div_stg,
    input logic [DIV_W-1:0]   div_act,
    input logic [SEL_W-1:0]   sel_stg,
    input logic [SEL_W-1:0]   sel_act
);

    localparam int CW = $clog2(SYNC_DLY + 1) + 1;

    logic          prev_req;
    logic [CW-1:0] same_cnt;
    logic          launch;

    assign launch = wr_en && acc_en && (addr == 2'd3) && wdata[0];

    // Count consecutive identical gate-request samples, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_req <= 1'b0;
            same_cnt <= '0;
        end else begin
            prev_req <= gate_req;
            if (gate_req == prev_req) begin
                if (same_cnt < CW'(SYNC_DLY)) same_cnt <= same_cnt + 1'b1;
            end else begin
                same_cnt <= CW'(1);
            end
        end
    end

    a_r5_status_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (same_cnt >= CW'(SYNC_DLY)) |-> (run_st == prev_req));

    a_r7_trig_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pend && !launch) |=> !trig_pend);

    a_r7_commit: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pend |=> (div_act == $past(div_stg) && sel_act == $past(sel_stg)));

    a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_pend |=> ($stable(div_act) && $stable(sel_act)));

    a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> ($stable(div_stg) && $stable(sel_stg) && !trig_pend));

    a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !run_st |-> !ce_out);

    a_r9_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ce_out |-> src_en[sel_act]);

endmodule

bind pclk_chan pclk_chan_chk #(
    .NUM_SRC (NUM_SRC),
    .DIV_W   (DIV_W),
    .SEL_W   (SEL_W),
    .SYNC_DLY(SYNC_DLY),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .src_en   (src_en),
    .ce_out   (ce_out),
    .gate_req (gate_req),
    .run_st   (run_st),
    .trig_pend(trig_pend),
    .div_stg  (div_stg),
    .div_act  (div_act),
    .sel_stg  (sel_stg),
    .sel_act  (sel_act)
);

// File: tb/pclk_chan_tb.sv
`timescale 1ns/100ps
// Bench for pclk_chan: a vector table of source/ratio settings with expected
// pulse counts, then directed checks for reset, lock, shadowing and gating.
module pclk_chan_tb;

    localparam int DATA_W   = 16;
    localparam int NUM_SRC  = 4;
    localparam int DIV_W    = 4;
    localparam int SYNC_DLY = 4;
    localparam int WIN      = 60;
    localparam int NVEC     = 7;

    // Vector layout: {source[1:0], ratio field[3:0], expected pulses in WIN[7:0]}.
    localparam logic [13:0] VEC [NVEC] = '{
        {2'd0, 4'd0,  8'd60},
        {2'd1, 4'd2,  8'd10},
        {2'd2, 4'd3,  8'd5},
        {2'd3, 4'd1,  8'd7},
        {2'd0, 4'd15, 8'd3},
        {2'd2, 4'd6,  8'd2},
        {2'd1, 4'd0,  8'd30}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               acc_en = 1'b0;
    logic               wr_en = 1'b0;
    logic [1:0]         addr = 2'd0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [DATA_W-1:0]  rdata;
    logic               hw_req = 1'b0;
    logic [NUM_SRC-1:0] src_en = '0;
    logic               ce_out;

    int n_chk = 0;
    int n_bad = 0;
    int bcyc  = 0;

    always #2.5 clk = ~clk;

    pclk_chan #(
        .DATA_W  (DATA_W),
        .NUM_SRC (NUM_SRC),
        .DIV_W   (DIV_W),
        .SYNC_DLY(SYNC_DLY)
    ) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .acc_en(acc_en),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .hw_req(hw_req),
        .src_en(src_en),
        .ce_out(ce_out)
    );

    // Source i ticks once every i+1 cycles, updated just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            bcyc = bcyc + 1;
            for (int i = 0; i < NUM_SRC; i++) src_en[i] = ((bcyc % (i + 1)) == 0);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic count_win(input int sel, input int n, output int pulses, output int off_tick);
        pulses   = 0;
        off_tick = 0;
        for (int i = 0; i < n; i++) begin
            if (ce_out) begin
                pulses = pulses + 1;
                if (!src_en[sel]) off_tick = off_tick + 1;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        logic [DATA_W-1:0] r;
        int pc;
        int ot;
        int prev_div;

        // Reset state (R2), checked at the ports through readback.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, r); chk("R2 gate reg after reset", int'(r), 0);
        rd(2'd1, r); chk("R2 ratio reg after reset", int'(r), 0);
        rd(2'd2, r); chk("R2 source reg after reset", int'(r), 0);
        rd(2'd3, r); chk("R2 trigger after reset", int'(r), 0);
        chk("R2 ce_out after reset", int'(ce_out), 0);

        // Writes without access permission are dropped (R3).
        wr(2'd1, 16'h0005);
        rd(2'd1, r); chk("R3 ratio write locked", int'(r), 0);
        wr(2'd0, 16'h0003);
        rd(2'd0, r); chk("R3 gate write locked", int'(r), 0);

        // Software gate on; status lags by SYNC_DLY edges (R4, R5, R1 layout).
        acc_en = 1'b1;
        wr(2'd0, 16'h0003);
        rd(2'd0, r); chk("R1 gate control bits", int'(r[1:0]), 3);
        repeat (SYNC_DLY - 1) @(negedge clk);
        rd(2'd0, r); chk("R5 status before lag", int'(r[4]), 0);
        @(negedge clk);
        rd(2'd0, r); chk("R5 status after lag", int'(r[4]), 1);

        // Vector table: stage, check shadow, trigger, check commit and rate.
        prev_div = 0;
        for (int v = 0; v < NVEC; v++) begin
            int s;
            int f;
            int e;
            s = int'(VEC[v][13:12]);
            f = int'(VEC[v][11:8]);
            e = int'(VEC[v][7:0]);
            wr(2'd1, DATA_W'(f));
            wr(2'd2, DATA_W'(s));
            rd(2'd1, r); chk("R6 active ratio before trigger", int'(r[11:8]), prev_div);
            chk("R1 staged ratio readback", int'(r[3:0]), f);
            wr(2'd3, 16'h0001);
            rd(2'd3, r); chk("R7 trigger pending", int'(r[0]), 1);
            @(negedge clk);
            rd(2'd3, r); chk("R7 trigger cleared", int'(r[0]), 0);
            rd(2'd1, r); chk("R7 ratio committed", int'(r[11:8]), f);
            rd(2'd2, r); chk("R7 source committed", int'(r[9:8]), s);
            count_win(s, WIN, pc, ot);
            chk("R8 pulse count", pc, e);
            chk("R9 pulses off source tick", ot, 0);
            prev_div = f;
        end

        // Staged ratio without trigger leaves the rate alone (R6).
        wr(2'd1, 16'h0009);
        rd(2'd1, r); chk("R6 active ratio held", int'(r[11:8]), 0);
        count_win(1, WIN, pc, ot);
        chk("R6 rate unchanged", pc, 30);

        // Locked trigger and gate writes have no effect (R3).
        acc_en = 1'b0;
        wr(2'd3, 16'h0001);
        rd(2'd3, r); chk("R3 locked trigger", int'(r[0]), 0);
        @(negedge clk);
        rd(2'd1, r); chk("R3 ratio not committed", int'(r[11:8]), 0);
        wr(2'd0, 16'h0000);
        rd(2'd0, r); chk("R3 gate unchanged", int'(r[1:0]), 3);
        acc_en = 1'b1;

        // Hardware control: software enable ignored, hw_req drives gate (R4, R10).
        wr(2'd0, 16'h0001);
        repeat (SYNC_DLY + 2) @(negedge clk);
        rd(2'd0, r); chk("R4 hw mode ignores sw enable", int'(r[4]), 0);
        count_win(1, 20, pc, ot);
        chk("R10 no pulses while stopped", pc, 0);
        hw_req = 1'b1;
        repeat (SYNC_DLY - 1) @(negedge clk);
        rd(2'd0, r); chk("R5 hw status before lag", int'(r[4]), 0);
        @(negedge clk);
        rd(2'd0, r); chk("R5 hw status after lag", int'(r[4]), 1);
        count_win(1, WIN, pc, ot);
        chk("R4 hw request runs channel", pc, 30);

        // Back to software control with enable 0 overrides hw_req (R4).
        wr(2'd0, 16'h0002);
        repeat (SYNC_DLY + 1) @(negedge clk);
        rd(2'd0, r); chk("R4 sw control stops channel", int'(r[4]), 0);
        count_win(1, 20, pc, ot);
        chk("R10 gated after stop", pc, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule